// File: doc/BRIEF.md
# Two-Bit Signed-Unit Float ALU

This block computes on a tiny number format that holds four values: zero, plus one, minus one and a single not-a-number code. Each value takes two bits. Plus one, zero and minus one use their two's complement patterns, and the one leftover pattern stands for NaN. An opcode selects one of several operations on two operands. The arithmetic group is add, subtract, negate, multiply, reciprocal and divide. The comparison group is bitwise identity, ordered equality, less, less-or-equal, greater and greater-or-equal.

Arithmetic operations produce a two-bit result, and comparisons produce a one-bit flag. Both are captured in output registers when `in_valid` is high, and they appear one clock later alongside `out_valid`. When `in_valid` is low the registers keep their contents. Overflow, such as plus one added to plus one, gives NaN. NaN propagates through every arithmetic operation.

Top module: `fp2_alu`

## Requirements
- R1: Codes are 00 = 0.0, 01 = +1.0, 11 = -1.0, 10 = NaN. Opcode 0 (add): 0.0 plus x gives x, and NaN plus anything gives NaN. +1.0 plus -1.0 gives 0.0. +1.0 plus +1.0 gives NaN, and so does -1.0 plus -1.0.
- R2: Opcode 2 (negate, op_a only) maps 0.0 to 0.0 and NaN to NaN, and swaps +1.0 with -1.0. Opcode 1 (subtract) gives op_a plus the negation of op_b.
- R3: Opcode 3 (multiply): a NaN in either operand gives NaN. Otherwise 0.0 in either operand gives 0.0, +1.0 gives the other operand unchanged, and -1.0 gives the other operand negated.
- R4: Opcode 4 (reciprocal, op_a only) gives NaN for 0.0 and for NaN, and gives ±1.0 back unchanged. Opcode 5 (divide) gives op_a multiplied by the reciprocal of op_b, so any division by 0.0 gives NaN.
- R5: Opcode 6 (identity) sets the flag exactly when the two codes are bitwise equal, so NaN is identical to NaN.
- R6: Opcode 7 (ordered equal) clears the flag whenever either operand is NaN. Otherwise it gives the same answer as identity.
- R7: Opcode 8 (less) sets the flag only for the pairs (-1,0), (-1,+1) and (0,+1). Opcode 10 (greater) is less with the operands swapped.
- R8: Opcode 9 (less-or-equal) is less OR ordered-equal. Opcode 11 (greater-or-equal) is greater OR ordered-equal.
- R9: Comparison opcodes write 0.0 to the result. Arithmetic opcodes write 0 to the flag. Opcodes 12 to 15 write NaN to the result and 0 to the flag.
- R10: Outputs for inputs accepted with in_valid high appear on the next clock, and out_valid is high in that cycle.
- R11: While in_valid is low, the result and the flag keep their previous values and out_valid is low on the next clock.
- R12: Reset (rst_n low) sets the result to 0.0, the flag to 0 and out_valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op_a | input | 2 | First operand |
| op_b | input | 2 | Second operand |
| opcode | input | 4 | Operation select |
| res_q | output | 2 | Registered result |
| flag_q | output | 1 | Registered comparison flag |
| out_valid | output | 1 | Result and flag were updated on this clock |

## Verification
The only state in the block is the output registers, so a fault in the datapath shows as a wrong code or flag one clock after the operation that exercised it. For this reason all twelve operations are driven over every operand pair. A broken clock enable shows in the first idle cycle, when the held result or flag changes even though nothing was accepted. A bad reset value shows before the first operation is accepted.

// File: rtl/fp2_alu_pkg.sv
package fp2_alu_pkg;
  localparam int CODE_W = 2;
  localparam int OP_W   = 4;

  typedef logic [CODE_W-1:0] fp2_t;
  typedef logic [OP_W-1:0]   fp2_op_t;

  localparam fp2_t FP2_ZERO = 2'b00;
  localparam fp2_t FP2_POS  = 2'b01;
  localparam fp2_t FP2_NAN  = 2'b10;
  localparam fp2_t FP2_NEG  = 2'b11;

  localparam fp2_op_t OP_ADD  = 4'd0;
  localparam fp2_op_t OP_SUB  = 4'd1;
  localparam fp2_op_t OP_NEGT = 4'd2;
  localparam fp2_op_t OP_MUL  = 4'd3;
  localparam fp2_op_t OP_RCP  = 4'd4;
  localparam fp2_op_t OP_DIV  = 4'd5;
  localparam fp2_op_t OP_IDEQ = 4'd6;
  localparam fp2_op_t OP_OEQ  = 4'd7;
  localparam fp2_op_t OP_LT   = 4'd8;
  localparam fp2_op_t OP_LE   = 4'd9;
  localparam fp2_op_t OP_GT   = 4'd10;
  localparam fp2_op_t OP_GE   = 4'd11;
endpackage

// File: rtl/fp2_arith.sv
module fp2_arith
  import fp2_alu_pkg::*;
(
  input  fp2_t    a,
  input  fp2_t    b,
  input  fp2_op_t op,
  output fp2_t    res,
  output logic    is_arith
);
  function automatic fp2_t f_neg(input fp2_t x);
    return fp2_t'(~x + 2'b01);
  endfunction

  function automatic fp2_t f_add(input fp2_t x, input fp2_t y);
    if (x == FP2_NAN || y == FP2_NAN) return FP2_NAN;
    // 2-bit wrap: +1+ +1 and -1+-1 both land on the NaN code
    return fp2_t'(x + y);
  endfunction

  function automatic fp2_t f_rcp(input fp2_t x);
    return (x == FP2_ZERO) ? FP2_NAN : x;
  endfunction

  function automatic fp2_t f_mul(input fp2_t x, input fp2_t y);
    if (x == FP2_NAN || y == FP2_NAN) return FP2_NAN;
    if (x == FP2_ZERO || y == FP2_ZERO) return FP2_ZERO;
    return (x == y) ? FP2_POS : FP2_NEG;
  endfunction

  fp2_t neg_b;
  assign neg_b = f_neg(b);

  always_comb begin
    is_arith = 1'b1;
    unique case (op)
      OP_ADD:  res = f_add(a, b);
      OP_SUB:  res = f_add(a, neg_b);
      OP_NEGT: res = f_neg(a);
      OP_MUL:  res = f_mul(a, b);
      OP_RCP:  res = f_rcp(a);
      OP_DIV:  res = f_mul(a, f_rcp(b));
      default: begin
        res      = FP2_NAN;
        is_arith = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fp2_cmp.sv
module fp2_cmp
  import fp2_alu_pkg::*;
(
  input  fp2_t    a,
  input  fp2_t    b,
  input  fp2_op_t op,
  output logic    flag,
  output logic    is_cmp
);
  logic ident, ord_eq, lt_ab, lt_ba;

  assign ident  = (a == b);
  assign ord_eq = ident && (a != FP2_NAN);
  // sum-of-products ordering over bits {a1,a0} and {b1,b0}
  assign lt_ab  = (a[1] & a[0] & ~b[1]) | (~a[1] & ~a[0] & ~b[1] & b[0]);
  assign lt_ba  = (b[1] & b[0] & ~a[1]) | (~b[1] & ~b[0] & ~a[1] & a[0]);

  always_comb begin
    is_cmp = 1'b1;
    unique case (op)
      OP_IDEQ: flag = ident;
      OP_OEQ:  flag = ord_eq;
      OP_LT:   flag = lt_ab;
      OP_LE:   flag = lt_ab | ord_eq;
      OP_GT:   flag = lt_ba;
      OP_GE:   flag = lt_ba | ord_eq;
      default: begin
        flag   = 1'b0;
        is_cmp = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fp2_alu.sv
module fp2_alu
  import fp2_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] op_a,
  input  logic [1:0] op_b,
  input  logic [3:0] opcode,
  output logic [1:0] res_q,
  output logic       flag_q,
  output logic       out_valid
);
  fp2_t arith_res, res_d;
  logic is_arith, is_cmp, cmp_flag, flag_d;

  fp2_arith u_arith (
    .a(op_a), .b(op_b), .op(opcode), .res(arith_res), .is_arith(is_arith)
  );

  fp2_cmp u_cmp (
    .a(op_a), .b(op_b), .op(opcode), .flag(cmp_flag), .is_cmp(is_cmp)
  );

  always_comb begin
    res_d  = is_cmp ? FP2_ZERO : arith_res;
    flag_d = is_arith ? 1'b0 : cmp_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= FP2_ZERO;
      flag_q    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_q  <= res_d;
        flag_q <= flag_d;
      end
    end
  end
endmodule

// File: rtl/fp2_alu_chk.sv
module fp2_alu_chk
  import fp2_alu_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] op_a,
  input logic [1:0] op_b,
  input logic [3:0] opcode,
  input logic [1:0] res_q,
  input logic       flag_q,
  input logic       out_valid
);
  assert_add_nan_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_ADD && (op_a == FP2_NAN || op_b == FP2_NAN))
      |=> res_q == FP2_NAN);

  assert_ident_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_IDEQ && op_a == op_b) |=> flag_q);

  assert_oeq_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_OEQ && (op_a == FP2_NAN || op_b == FP2_NAN))
      |=> !flag_q);

  assert_arith_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode <= OP_DIV) |=> !flag_q);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_q) && $stable(flag_q) && !out_valid));
endmodule

bind fp2_alu fp2_alu_chk u_fp2_alu_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .opcode(opcode), .res_q(res_q), .flag_q(flag_q), .out_valid(out_valid)
);

// File: tb/test_fp2_alu.sv
module test_fp2_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] op_a = 2'b00, op_b = 2'b00;
  logic [3:0] opcode = 4'd0;
  logic [1:0] res_q;
  logic       flag_q, out_valid;

  int errors = 0, checks = 0;
  logic [1:0] exp_res = 2'b00;
  logic       exp_flag = 1'b0, exp_valid = 1'b0;

  always #2.5 clk = ~clk;

  fp2_alu i_fp2_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .res_q(res_q), .flag_q(flag_q), .out_valid(out_valid)
  );

  function automatic bit is_nan(input logic [1:0] c);
    return c == 2'b10;
  endfunction
  function automatic int to_int(input logic [1:0] c);
    case (c)
      2'b01:   return 1;
      2'b11:   return -1;
      default: return 0;
    endcase
  endfunction
  function automatic logic [1:0] from_int(input int v);
    if (v == 0) return 2'b00;
    if (v == 1) return 2'b01;
    if (v == -1) return 2'b11;
    return 2'b10;
  endfunction

  function automatic logic [1:0] ref_res(input int op, input logic [1:0] a, input logic [1:0] b);
    bit an = is_nan(a), bn = is_nan(b);
    int va = to_int(a), vb = to_int(b);
    case (op)
      0: return (an || bn) ? 2'b10 : from_int(va + vb);
      1: return (an || bn) ? 2'b10 : from_int(va - vb);
      2: return an ? 2'b10 : from_int(-va);
      3: return (an || bn) ? 2'b10 : from_int(va * vb);
      4: return (an || va == 0) ? 2'b10 : from_int(va);
      5: return (an || bn || vb == 0) ? 2'b10 : from_int(va * vb);
      6, 7, 8, 9, 10, 11: return 2'b00;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic ref_flag(input int op, input logic [1:0] a, input logic [1:0] b);
    bit ok = !is_nan(a) && !is_nan(b);
    int va = to_int(a), vb = to_int(b);
    case (op)
      6:  return a == b;
      7:  return ok && va == vb;
      8:  return ok && va < vb;
      9:  return ok && va <= vb;
      10: return ok && va > vb;
      11: return ok && va >= vb;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0: return "R1";
      1, 2: return "R2";
      3: return "R3";
      4, 5: return "R4";
      6: return "R5";
      7: return "R6";
      8, 10: return "R7";
      9, 11: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(input string req);
    checks++;
    if (res_q !== exp_res || flag_q !== exp_flag || out_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s: res=%b flag=%b valid=%b expected res=%b flag=%b valid=%b",
               req, res_q, flag_q, out_valid, exp_res, exp_flag, exp_valid);
    end
  endtask

  // called at a falling edge; drives, models the next rising edge, checks at the next falling edge
  task automatic step(input bit v, input int op, input logic [1:0] a, input logic [1:0] b,
                      input string req);
    in_valid = v; opcode = op[3:0]; op_a = a; op_b = b;
    if (v) begin
      exp_res  = ref_res(op, a, b);
      exp_flag = ref_flag(op, a, b);
    end
    exp_valid = v;
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    compare("R12");                       // R12: state under reset
    rst_n = 1'b1;
    @(negedge clk);
    compare("R12");
    // exhaustive sweep of all opcodes and operand pairs (R1..R10)
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          step(1'b1, op, a[1:0], b[1:0], req_of(op));
    // R11: idle cycles with changing inputs must hold result and flag
    step(1'b1, 8, 2'b11, 2'b01, "R7");
    step(1'b0, 0, 2'b10, 2'b10, "R11");
    step(1'b0, 3, 2'b01, 2'b11, "R11");
    step(1'b1, 0, 2'b01, 2'b11, "R1");
    step(1'b0, 6, 2'b00, 2'b00, "R11");
    step(1'b0, 2, 2'b01, 2'b01, "R11");
    // R10: back-to-back operations each show on the next clock
    step(1'b1, 1, 2'b01, 2'b11, "R10");
    step(1'b1, 11, 2'b00, 2'b00, "R10");
    step(1'b1, 5, 2'b11, 2'b11, "R10");
    // R12: reset in mid-run
    rst_n = 1'b0;
    exp_res = 2'b00; exp_flag = 1'b0; exp_valid = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    compare("R12");
    rst_n = 1'b1;
    step(1'b1, 7, 2'b01, 2'b01, "R6");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule